// File: doc/BRIEF.md
# Fine-Rate Parity Puncturer

The puncturer sits directly after a systematic channel encoder and thins out the parity bits so that the transmitted code rate can fall between the encoder's coarse rates. Each incoming bit carries a tag saying whether it is systematic or parity, plus a frame-start marker. Bits enter and leave under valid/ready handshakes. Systematic bits always pass. Parity bits are kept at a fraction n/16 of the incoming parity stream, where n is chosen once per frame in the range 8 to 16.

With an encoder rate r, the resulting rate is r/(r + (n/16)(1-r)). Five coarse encoder rates combined with nine fine settings give a ladder of 45 rates. The keep decisions come from a running fractional accumulator, so the kept parity bits are spread evenly through the frame. The pattern restarts at every frame, so it can be repeated. For each frame the block reports how many bits it has sent. It also flags an out-of-range setting, which it treats as full transparency.

Top module: `fine_punct`

## Requirements
- R1: A systematic bit (in_par_i = 0) that is accepted always appears at the output, with its data value and tag unchanged.
- R2: For each accepted parity bit (in_par_i = 1), n is added to a running sum. The bit is kept when the sum reaches 16 or more, and 16 is then subtracted. Otherwise the bit is dropped. A frame carrying P parity bits therefore keeps floor(P*n/16) of them.
- R3: The running sum is treated as zero on the beat that carries in_sof_i = 1. The setting fine_n_i is sampled on that beat and held for the rest of the frame.
- R4: With n = 16, every parity bit is kept and the output stream equals the input stream.
- R5: A setting fine_n_i below 8 or above 16 is treated as 16. In that case rate_err_o reads 1 from the cycle after the frame-start beat until the next frame start that carries a valid setting.
- R6: Kept bits leave in arrival order, with no loss and no duplication, under any pattern of out_ready_i. in_ready_o is 1 whenever no output is pending.
- R7: tx_count_o gives the number of bits kept in the current frame. It is updated one cycle after the accepting edge, and the frame-start beat restarts it at 1 if that beat is kept and at 0 if it is dropped.
- R8: out_sof_o is 1 on the first kept bit of each frame and 0 on all other output bits, including when the frame-start beat itself was dropped.
- R9: While out_valid_o = 1 and out_ready_i = 0, the output bit, its tags and out_valid_o hold their values.
- R10: After reset, out_valid_o, tx_count_o and rate_err_o are 0 and in_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input bit valid |
| in_ready_o | output | 1 | Block can accept an input bit |
| in_data_i | input | 1 | Input bit value |
| in_par_i | input | 1 | 1 = parity bit, 0 = systematic bit |
| in_sof_i | input | 1 | First bit of a frame |
| fine_n_i | input | 5 | Fine keep numerator n (valid 8..16), sampled with in_sof_i |
| out_valid_o | output | 1 | Output bit valid |
| out_ready_i | input | 1 | Downstream accepts the output bit |
| out_data_o | output | 1 | Output bit value |
| out_par_o | output | 1 | Output bit is parity |
| out_sof_o | output | 1 | First kept bit of a frame |
| tx_count_o | output | 16 | Bits kept so far in the current frame |
| rate_err_o | output | 1 | Out-of-range setting seen for the current frame |

## Verification
A kept bit shows up on the output register one cycle after the edge that accepts it. tx_count_o and rate_err_o change on that same edge. The bench drives inputs on the falling edge and samples a little after it, so every handshake is read as the value that the next rising edge will act on. A driver computes the expected kept bits from the accumulator rule and queues them, and a monitor pops the queue only on real output handshakes. The frame-level results (kept parity total against floor(P*n/16), tx_count_o and rate_err_o) are checked only after the queue has drained and the output has gone idle, so no pending bit is still in flight.

// File: rtl/fine_punct_pkg.sv
package fine_punct_pkg;
  localparam int unsigned RATE_DEN = 16;
  localparam int unsigned RATE_MIN = 8;
  localparam int unsigned CNT_W    = 16;

  typedef struct packed {
    logic sof;
    logic par;
    logic data;
  } beat_t;
endpackage

// File: rtl/fp_rate_sel.sv
module fp_rate_sel #(
  parameter int unsigned DEN  = 16,
  parameter int unsigned NMIN = 8,
  localparam int unsigned NW  = $clog2(DEN) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sof_fire_i,
  input  logic          sof_i,
  input  logic [NW-1:0] n_i,
  output logic [NW-1:0] n_eff_o,
  output logic          err_o
);
  localparam logic [NW-1:0] DEN_V = NW'(DEN);
  localparam logic [NW-1:0] MIN_V = NW'(NMIN);

  logic          bad;
  logic [NW-1:0] n_clamp, n_q;

  assign bad     = (n_i < MIN_V) || (n_i > DEN_V);
  assign n_clamp = bad ? DEN_V : n_i;
  assign n_eff_o = sof_i ? n_clamp : n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q   <= DEN_V;
      err_o <= 1'b0;
    end else if (sof_fire_i) begin
      n_q   <= n_clamp;
      err_o <= bad;
    end
  end
endmodule

// File: rtl/fp_keep_acc.sv
module fp_keep_acc #(
  parameter int unsigned DEN = 16,
  localparam int unsigned NW = $clog2(DEN) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          sof_i,
  input  logic          par_i,
  input  logic [NW-1:0] n_i,
  output logic          keep_o
);
  localparam logic [NW-1:0] DEN_V = NW'(DEN);

  logic [NW-1:0] acc_q, base, sum;
  logic          hit;

  assign base   = sof_i ? '0 : acc_q;
  assign sum    = base + n_i;
  assign hit    = sum >= DEN_V;
  // systematic bits bypass the fraction
  assign keep_o = !par_i || hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (fire_i) begin
      if (par_i)      acc_q <= hit ? (sum - DEN_V) : sum;
      else if (sof_i) acc_q <= '0;
    end
  end
endmodule

// File: rtl/fp_out_stage.sv
module fp_out_stage
  import fine_punct_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  beat_t beat_i,
  input  logic  ready_i,
  output logic  valid_o,
  output beat_t beat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      beat_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      beat_o  <= beat_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fp_tx_count.sv
module fp_tx_count #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          sof_i,
  input  logic          keep_i,
  output logic [CW-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               count_o <= '0;
    else if (fire_i && sof_i)  count_o <= CW'(keep_i);
    else if (fire_i && keep_i) count_o <= count_o + CW'(1);
  end
endmodule

// File: rtl/fine_punct.sv
module fine_punct
  import fine_punct_pkg::*;
#(
  parameter int unsigned DEN  = RATE_DEN,
  parameter int unsigned NMIN = RATE_MIN,
  parameter int unsigned CW   = CNT_W,
  localparam int unsigned NW  = $clog2(DEN) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic          in_data_i,
  input  logic          in_par_i,
  input  logic          in_sof_i,
  input  logic [NW-1:0] fine_n_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic          out_data_o,
  output logic          out_par_o,
  output logic          out_sof_o,
  output logic [CW-1:0] tx_count_o,
  output logic          rate_err_o
);
  logic          in_fire, keep, load, sof_pend_q;
  logic [NW-1:0] n_eff;
  beat_t         beat_in, beat_out;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign in_fire    = in_valid_i && in_ready_o;
  assign load       = in_fire && keep;

  fp_rate_sel #(.DEN(DEN), .NMIN(NMIN)) u_rate (
    .clk_i, .rst_ni,
    .sof_fire_i (in_fire && in_sof_i),
    .sof_i      (in_sof_i),
    .n_i        (fine_n_i),
    .n_eff_o    (n_eff),
    .err_o      (rate_err_o)
  );

  fp_keep_acc #(.DEN(DEN)) u_acc (
    .clk_i, .rst_ni,
    .fire_i (in_fire),
    .sof_i  (in_sof_i),
    .par_i  (in_par_i),
    .n_i    (n_eff),
    .keep_o (keep)
  );

  // carry the frame marker forward past a dropped first beat
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sof_pend_q <= 1'b0;
    else if (in_fire) sof_pend_q <= !keep && (in_sof_i || sof_pend_q);
  end

  assign beat_in = '{sof: in_sof_i || sof_pend_q, par: in_par_i, data: in_data_i};

  fp_out_stage u_out (
    .clk_i, .rst_ni,
    .load_i  (load),
    .beat_i  (beat_in),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .beat_o  (beat_out)
  );

  assign out_data_o = beat_out.data;
  assign out_par_o  = beat_out.par;
  assign out_sof_o  = beat_out.sof;

  fp_tx_count #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni,
    .fire_i  (in_fire),
    .sof_i   (in_sof_i),
    .keep_i  (keep),
    .count_o (tx_count_o)
  );
endmodule

// File: rtl/fine_punct_chk.sv
module fine_punct_chk #(
  parameter int unsigned DEN  = 16,
  parameter int unsigned NMIN = 8,
  parameter int unsigned CW   = 16,
  localparam int unsigned NW  = $clog2(DEN) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          in_par_i,
  input logic          in_sof_i,
  input logic [NW-1:0] fine_n_i,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic          out_data_o,
  input logic          out_par_o,
  input logic          out_sof_o,
  input logic [CW-1:0] tx_count_o,
  input logic          rate_err_o
);
  logic in_fire, n_bad;
  assign in_fire = in_valid_i && in_ready_o;
  assign n_bad   = (fine_n_i < NW'(NMIN)) || (fine_n_i > NW'(DEN));

  a_r1_sys_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fire && !in_par_i |=> out_valid_o && !out_par_o);

  a_r4_full_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fire && in_sof_i && fine_n_i == NW'(DEN) |=> out_valid_o);

  a_r5_err_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fire && in_sof_i |=> rate_err_o == $past(n_bad));

  a_r6_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  a_r7_count_sys: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fire && !in_sof_i && !in_par_i |=> tx_count_o == $past(tx_count_o) + CW'(1));

  a_r8_sof_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fire && in_sof_i && !in_par_i |=> out_sof_o);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
      && $stable(out_par_o) && $stable(out_sof_o));
endmodule

bind fine_punct fine_punct_chk #(.DEN(DEN), .NMIN(NMIN), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_par_i    (in_par_i),
  .in_sof_i    (in_sof_i),
  .fine_n_i    (fine_n_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_par_o   (out_par_o),
  .out_sof_o   (out_sof_o),
  .tx_count_o  (tx_count_o),
  .rate_err_o  (rate_err_o)
);

// File: tb/fine_punct_tb_top.sv
module fine_punct_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0, in_data_i = 1'b0, in_par_i = 1'b0, in_sof_i = 1'b0;
  logic [4:0]  fine_n_i = 5'd16;
  logic        out_ready_i = 1'b1;
  logic        in_ready_o, out_valid_o, out_data_o, out_par_o, out_sof_o, rate_err_o;
  logic [15:0] tx_count_o;

  int checks = 0, errors = 0;
  bit done = 0;
  bit bp_on = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] rlfsr = 16'h1D2B;
  logic [2:0] exp_q[$];
  int par_seen = 0;
  logic [2:0] held;
  bit held_v = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fine_punct dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // downstream ready pattern
  always @(negedge clk_i) begin
    rlfsr <= {rlfsr[14:0], rlfsr[15] ^ rlfsr[13] ^ rlfsr[12] ^ rlfsr[10]};
    out_ready_i <= bp_on ? rlfsr[0] : 1'b1;
  end

  // monitor: scoreboard pop on each output handshake, hold check (R9)
  always @(negedge clk_i) begin
    #1;
    if (rst_ni) begin
      if (held_v) begin
        chk(out_valid_o && {out_sof_o, out_par_o, out_data_o} == held, "R9",
            "held output", int'({out_sof_o, out_par_o, out_data_o}), int'(held));
        held_v = 0;
      end
      if (out_valid_o && !out_ready_i) begin
        held = {out_sof_o, out_par_o, out_data_o};
        held_v = 1;
      end
      if (out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(0, "R6", "unexpected output bit", int'({out_sof_o, out_par_o, out_data_o}), -1);
        end else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          chk({out_sof_o, out_par_o, out_data_o} == e, e[1] ? "R2" : "R1",
              "output beat {sof,par,data} (R6 R8 order)",
              int'({out_sof_o, out_par_o, out_data_o}), int'(e));
          if (out_par_o) par_seen++;
        end
      end
    end
  end

  // ptype 0: systematic every third bit, 1: all parity, 2: all systematic
  task automatic send_frame(input int n, input int len, input int ptype, input string req);
    int nn, acc, cnt, npar;
    bit pend, bad;
    bad  = (n < 8) || (n > 16);
    nn   = bad ? 16 : n;
    acc  = 0; cnt = 0; npar = 0; pend = 1;
    par_seen = 0;
    for (int i = 0; i < len; i++) begin
      bit par, d, keep;
      par = (ptype == 1) ? 1'b1 : (ptype == 2) ? 1'b0 : (i % 3 != 0);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      d = lfsr[0];
      keep = 1;
      if (par) begin
        npar++;
        acc += nn;
        if (acc >= 16) acc -= 16; else keep = 0;
      end
      if (keep) begin
        exp_q.push_back({pend, par, d});
        pend = 0;
        cnt++;
      end
      @(negedge clk_i);
      in_valid_i = 1; in_sof_i = (i == 0); in_par_i = par; in_data_i = d;
      fine_n_i = 5'(n);
      forever begin
        #1;
        if (in_ready_o) begin
          @(posedge clk_i);
          break;
        end
        @(negedge clk_i);
      end
    end
    @(negedge clk_i);
    in_valid_i = 0; in_sof_i = 0;
    while (exp_q.size() != 0) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
    #2;
    chk(!out_valid_o, "R6", "output idle after frame", int'(out_valid_o), 0);
    chk(par_seen == (npar * nn) / 16, "R2", {req, " kept parity total"},
        par_seen, (npar * nn) / 16);
    chk(int'(tx_count_o) == cnt, "R7", {req, " tx_count"}, int'(tx_count_o), cnt);
    chk(rate_err_o == bad, "R5", {req, " rate_err"}, int'(rate_err_o), int'(bad));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk(!out_valid_o, "R10", "out_valid in reset", int'(out_valid_o), 0);
    chk(in_ready_o, "R10", "in_ready in reset", int'(in_ready_o), 1);
    chk(tx_count_o == 0, "R10", "tx_count in reset", int'(tx_count_o), 0);
    chk(!rate_err_o, "R10", "rate_err in reset", int'(rate_err_o), 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);

    send_frame(16, 30, 0, "R4 n=16 transparent");
    send_frame(8,  30, 0, "R2 n=8 mixed");
    send_frame(12, 40, 1, "R2 n=12 all parity");
    send_frame(9,  33, 0, "R2 n=9");
    send_frame(15, 47, 1, "R2 n=15");
    send_frame(16, 20, 2, "R1 all systematic");
    // R3: short frame then restart, residue must not carry over
    send_frame(12, 3, 1, "R3 short frame");
    send_frame(12, 3, 1, "R3 restart");
    // R8: first beat is a dropped parity bit
    send_frame(8, 9, 1, "R8 dropped first beat");
    // R5 clamps
    send_frame(5,  24, 0, "R5 n=5 clamped");
    send_frame(20, 24, 0, "R5 n=20 clamped");
    send_frame(10, 24, 0, "R5 err cleared n=10");
    // R6 backpressure
    bp_on = 1;
    send_frame(11, 60, 0, "R6 backpressure n=11");
    send_frame(8,  45, 1, "R6 backpressure n=8");
    send_frame(16, 30, 0, "R6 backpressure n=16");
    bp_on = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule